// File: doc/BRIEF.md
# Packet-DMA Channel Control Register Block

This block is the register front end of a two-channel packet-DMA disk host controller. A host bus presents byte addresses with single-cycle write and read strobes. The block decodes these strobes into per-channel registers: control, status, descriptor count, next-descriptor pointer, and the inbound and outbound FIFO thresholds. It also decodes one global mode-lock byte.

From these registers the block drives the packet engine of each channel. It provides a held engine reset, a single-cycle start pulse, an engine-busy flag, the PIO mode field, the descriptor and threshold values, and a maskable interrupt.

The engine reports three kinds of event per channel: packet done, unexpected interrupt, and bus or parity error. The block latches these events in the status register until software reads it. The read returns the latched bits and then clears them. The start pulse can only be produced once the global lock byte holds the enable key. After that the key cannot be changed.

Top module: `pktdma_chan_ctrl`

## Requirements
- R1: Channel n occupies byte addresses 0x80 + 0x20·n. Within a channel, the offsets are: control 0x00, status 0x02, descriptor count 0x04 (16 bit), next pointer 0x0C (32 bit), inbound threshold 0x14 (16 bit) and outbound threshold 0x16 (16 bit). A write lands on the matching output in the cycle after the strobe. A read returns the value on `bus_rdata` one cycle after `bus_rd`; in every cycle without a read, `bus_rdata` is 0.
- R2: The control fields are: bit 8 interrupt mask (1 = masked), bit 5 engine reset, bits 1:0 PIO mode (3 selects mode 4). The control register reads back these fields only. Bit 7 (start) always reads as 0.
- R3: Writing control with bit 7 set gives a one-cycle `eng_go` pulse for that channel in the cycle after the write. This happens only if all three conditions hold: the lock byte holds 7, the written bit 5 is 0, and the stored reset bit is 0. Otherwise the start request is dropped.
- R4: The lock byte at 0xC7 stores the low data byte of each write until it holds 7. From then on, writes to it are ignored. It reads back its value.
- R5: While the stored reset bit is 1, `eng_reset` is high and `eng_busy` is low. Engine events are not latched in this state. Writing the bit back to 0 returns the channel to idle.
- R6: The status register latches the events on these bits: done on bit 6, unexpected interrupt on bit 4, bus or parity error on bit 0. A latched bit stays set until the status register is read.
- R7: A status read returns the latched bits and clears them. An event that arrives in the same cycle as the read stays latched for the next read.
- R8: `irq` for a channel is high when any status bit is latched and the mask bit is 0.
- R9: The low 3 bits of a write to the next pointer are discarded. Those bits read as 0 and are driven as 0 on `cpb_next`.
- R10: A start pulse sets `eng_busy`. A done event clears it. If both happen in the same cycle, busy is set.
- R11: After reset, control reads 0x0100 (masked, out of engine reset, PIO 0). All other registers and the lock byte are 0, and every engine output is low.
- R12: The two channels are independent: an access to one never changes the other. Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after `bus_rd` |
| evt_done | input | 2 | Per-channel packet-done event |
| evt_uirq | input | 2 | Per-channel unexpected-interrupt event |
| evt_perr | input | 2 | Per-channel bus/parity error event |
| eng_reset | output | 2 | Per-channel engine reset level |
| eng_go | output | 2 | Per-channel start pulse |
| eng_busy | output | 2 | Per-channel engine-busy flag |
| irq | output | 2 | Per-channel masked interrupt |
| pio_mode | output | 4 | PIO mode, 2 bits per channel |
| cpb_count | output | 32 | Descriptor count, 16 bits per channel |
| cpb_next | output | 64 | Next descriptor pointer, 32 bits per channel |
| fifo_in_thr | output | 32 | Inbound FIFO threshold, 16 bits per channel |
| fifo_out_thr | output | 32 | Outbound FIFO threshold, 16 bits per channel |

## Verification
The bench targets several corner cases, each paired with the wrong behaviour it would expose:
- A start write before the key is set. A design that ignored the lock would start the engine early.
- A start write combined with reset, and one issued while reset is held. A design that let these through would start an engine that is held in reset.
- A status read in the same cycle as a new event. A design that cleared on read unconditionally would lose an error.
- Rewrites of the lock after the key is set. Without the sticky behaviour, software could disable start operation.
- Cross-channel accesses and a misaligned pointer write. These expose a decode that aliases the channels, or a pointer that keeps its low bits.

// File: rtl/pktdma_regs_pkg.sv
// Shared constants for the packet-DMA channel register block: the address
// layout and the bit positions that the engine and the software both rely on.
package pktdma_regs_pkg;
    localparam int unsigned CH_BASE   = 'h80;
    localparam int unsigned CH_STRIDE = 'h20;
    localparam int unsigned OFS_CTRL  = 'h00;
    localparam int unsigned OFS_STAT  = 'h02;
    localparam int unsigned OFS_CNT   = 'h04;
    localparam int unsigned OFS_NEXT  = 'h0C;
    localparam int unsigned OFS_FIN   = 'h14;
    localparam int unsigned OFS_FOUT  = 'h16;
    localparam int unsigned LOCK_ADDR = 'hC7;
    localparam int unsigned LOCK_KEY  = 7;
    localparam int unsigned CTL_MASK  = 8;
    localparam int unsigned CTL_GO    = 7;
    localparam int unsigned CTL_RST   = 5;
    localparam int unsigned ST_DONE   = 6;
    localparam int unsigned ST_UIRQ   = 4;
    localparam int unsigned ST_PERR   = 0;
    localparam int unsigned PTR_ALIGN = 3;
endpackage

// File: rtl/pktdma_mode_lock.sv
// Global mode-lock byte. It keeps the last written byte until that byte
// equals the key; from then on it is frozen. It assumes the caller has
// already decoded the address into wr_en.
module pktdma_mode_lock
    import pktdma_regs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wdata,
    output logic [7:0] lock_val,
    output logic       lock_open
);
    logic [7:0] lock_q;

    // Holds the lock byte; sticky once the key is reached.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lock_q <= '0;
        else if (wr_en && (lock_q != 8'(LOCK_KEY)))
            lock_q <= wdata;
    end

    assign lock_val  = lock_q;
    assign lock_open = (lock_q == 8'(LOCK_KEY));

    assert_key_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(lock_q) == 8'(LOCK_KEY)) |-> (lock_q == 8'(LOCK_KEY)));
endmodule

// File: rtl/pktdma_chan_regs.sv
// One channel's register set: control, latched status, descriptor count,
// next pointer and FIFO thresholds, plus the start-pulse and busy logic.
// It assumes wr_en/rd_en are already qualified with this channel's address
// window and that ofs is the byte offset inside the window.
module pktdma_chan_regs
    import pktdma_regs_pkg::*;
#(
    parameter int DW    = 32,
    parameter int CNT_W = 16,
    parameter int THR_W = 16,
    parameter int OFS_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [OFS_W-1:0] ofs,
    input  logic [DW-1:0]    wdata,
    input  logic             lock_open,
    input  logic             evt_done,
    input  logic             evt_uirq,
    input  logic             evt_perr,
    output logic [DW-1:0]    rdata,
    output logic             eng_reset,
    output logic             eng_go,
    output logic             eng_busy,
    output logic             irq,
    output logic [1:0]       pio_mode,
    output logic [CNT_W-1:0] cpb_count,
    output logic [DW-1:0]    cpb_next,
    output logic [THR_W-1:0] fifo_in_thr,
    output logic [THR_W-1:0] fifo_out_thr
);
    logic wr_ctrl, wr_cnt, wr_next, wr_fin, wr_fout, rd_stat;
    logic mask_q, rst_q, rst_d, go_q, go_d, busy_q, busy_d;
    logic [1:0]       pio_q;
    logic [7:0]       stat_q, stat_d, ev;
    logic [CNT_W-1:0] cnt_q;
    logic [DW-1:0]    next_q;
    logic [THR_W-1:0] fin_q, fout_q;

    // Offset decode of the qualified strobes.
    always_comb begin
        wr_ctrl = wr_en && (ofs == OFS_W'(OFS_CTRL));
        wr_cnt  = wr_en && (ofs == OFS_W'(OFS_CNT));
        wr_next = wr_en && (ofs == OFS_W'(OFS_NEXT));
        wr_fin  = wr_en && (ofs == OFS_W'(OFS_FIN));
        wr_fout = wr_en && (ofs == OFS_W'(OFS_FOUT));
        rd_stat = rd_en && (ofs == OFS_W'(OFS_STAT));
    end

    // Next-state of reset, start, status and busy.
    always_comb begin
        ev = '0;
        ev[ST_DONE] = evt_done;
        ev[ST_UIRQ] = evt_uirq;
        ev[ST_PERR] = evt_perr;
        rst_d  = wr_ctrl ? wdata[CTL_RST] : rst_q;
        go_d   = wr_ctrl && wdata[CTL_GO] && !wdata[CTL_RST] && !rst_q && lock_open;
        stat_d = rst_d ? '0 : ((rd_stat ? 8'h00 : stat_q) | ev);
        if (rst_d)         busy_d = 1'b0;
        else if (go_d)     busy_d = 1'b1;
        else if (evt_done) busy_d = 1'b0;
        else               busy_d = busy_q;
    end

    // Control fields and engine state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= 1'b1;
            rst_q  <= 1'b0;
            pio_q  <= '0;
            go_q   <= 1'b0;
            busy_q <= 1'b0;
            stat_q <= '0;
        end else begin
            if (wr_ctrl) begin
                mask_q <= wdata[CTL_MASK];
                pio_q  <= wdata[1:0];
            end
            rst_q  <= rst_d;
            go_q   <= go_d;
            busy_q <= busy_d;
            stat_q <= stat_d;
        end
    end

    // Plain data registers for the engine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            next_q <= '0;
            fin_q  <= '0;
            fout_q <= '0;
        end else begin
            if (wr_cnt)  cnt_q  <= wdata[CNT_W-1:0];
            if (wr_next) next_q <= {wdata[DW-1:PTR_ALIGN], {PTR_ALIGN{1'b0}}};
            if (wr_fin)  fin_q  <= wdata[THR_W-1:0];
            if (wr_fout) fout_q <= wdata[THR_W-1:0];
        end
    end

    // Read-back value selected by offset; the start bit is never returned.
    always_comb begin
        rdata = '0;
        case (ofs)
            OFS_W'(OFS_CTRL): begin
                rdata[CTL_MASK] = mask_q;
                rdata[CTL_RST]  = rst_q;
                rdata[1:0]      = pio_q;
            end
            OFS_W'(OFS_STAT): rdata = DW'(stat_q);
            OFS_W'(OFS_CNT):  rdata = DW'(cnt_q);
            OFS_W'(OFS_NEXT): rdata = next_q;
            OFS_W'(OFS_FIN):  rdata = DW'(fin_q);
            OFS_W'(OFS_FOUT): rdata = DW'(fout_q);
            default:          rdata = '0;
        endcase
    end

    assign eng_reset    = rst_q;
    assign eng_go       = go_q;
    assign eng_busy     = busy_q;
    assign irq          = (stat_q != '0) && !mask_q;
    assign pio_mode     = pio_q;
    assign cpb_count    = cnt_q;
    assign cpb_next     = next_q;
    assign fifo_in_thr  = fin_q;
    assign fifo_out_thr = fout_q;

    assert_go_needs_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
        eng_go |-> $past(wr_ctrl && wdata[CTL_GO] && lock_open));
    assert_go_not_in_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        eng_go |-> !eng_reset);
    assert_busy_low_in_reset_R5: assert property (@(posedge clk) disable iff (!rst_n)
        eng_reset |-> !eng_busy);
    assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_stat && (ev == 8'h00)) |-> (stat_q == 8'h00));
endmodule

// File: rtl/pktdma_chan_ctrl.sv
// Top of the register block: decodes the host byte address into the global
// lock byte and each channel window, and registers read data for one cycle.
// It assumes single-cycle strobes and exact byte addresses for each register.
module pktdma_chan_ctrl
    import pktdma_regs_pkg::*;
#(
    parameter int NCH   = 2,
    parameter int AW    = 8,
    parameter int DW    = 32,
    parameter int CNT_W = 16,
    parameter int THR_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [AW-1:0]      bus_addr,
    input  logic [DW-1:0]      bus_wdata,
    output logic [DW-1:0]      bus_rdata,
    input  logic [NCH-1:0]     evt_done,
    input  logic [NCH-1:0]     evt_uirq,
    input  logic [NCH-1:0]     evt_perr,
    output logic [NCH-1:0]     eng_reset,
    output logic [NCH-1:0]     eng_go,
    output logic [NCH-1:0]     eng_busy,
    output logic [NCH-1:0]     irq,
    output logic [2*NCH-1:0]   pio_mode,
    output logic [CNT_W*NCH-1:0] cpb_count,
    output logic [DW*NCH-1:0]  cpb_next,
    output logic [THR_W*NCH-1:0] fifo_in_thr,
    output logic [THR_W*NCH-1:0] fifo_out_thr
);
    localparam int OFS_W = $clog2(CH_STRIDE);

    logic          lock_hit, lock_open;
    logic [7:0]    lock_val;
    logic [NCH-1:0] ch_hit;
    logic [DW-1:0] chan_rd [NCH];
    logic [DW-1:0] rdata_d;

    assign lock_hit = (bus_addr == AW'(LOCK_ADDR));

    pktdma_mode_lock i_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_wr && lock_hit),
        .wdata     (bus_wdata[7:0]),
        .lock_val  (lock_val),
        .lock_open (lock_open)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        localparam logic [AW-1:0] BASE = AW'(CH_BASE + g * CH_STRIDE);
        assign ch_hit[g] = (bus_addr[AW-1:OFS_W] == BASE[AW-1:OFS_W]);

        pktdma_chan_regs #(.DW(DW), .CNT_W(CNT_W), .THR_W(THR_W), .OFS_W(OFS_W)) i_chan (
            .clk          (clk),
            .rst_n        (rst_n),
            .wr_en        (bus_wr && ch_hit[g]),
            .rd_en        (bus_rd && ch_hit[g]),
            .ofs          (bus_addr[OFS_W-1:0]),
            .wdata        (bus_wdata),
            .lock_open    (lock_open),
            .evt_done     (evt_done[g]),
            .evt_uirq     (evt_uirq[g]),
            .evt_perr     (evt_perr[g]),
            .rdata        (chan_rd[g]),
            .eng_reset    (eng_reset[g]),
            .eng_go       (eng_go[g]),
            .eng_busy     (eng_busy[g]),
            .irq          (irq[g]),
            .pio_mode     (pio_mode[2*g +: 2]),
            .cpb_count    (cpb_count[CNT_W*g +: CNT_W]),
            .cpb_next     (cpb_next[DW*g +: DW]),
            .fifo_in_thr  (fifo_in_thr[THR_W*g +: THR_W]),
            .fifo_out_thr (fifo_out_thr[THR_W*g +: THR_W])
        );
    end

    // Read-data mux over the lock byte and the hit channel window.
    always_comb begin
        rdata_d = lock_hit ? DW'(lock_val) : '0;
        for (int i = 0; i < NCH; i++)
            if (ch_hit[i]) rdata_d = rdata_d | chan_rd[i];
    end

    // Read data register: one cycle after the strobe, zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rdata_d;
        else             bus_rdata <= '0;
    end

    assert_onechannel_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(eng_go & ~$past(ch_hit & {NCH{bus_wr}})) |-> (eng_go == (eng_go & $past(ch_hit))));
endmodule

// File: tb/test_pktdma_chan_ctrl.sv
module test_pktdma_chan_ctrl;
    localparam time CYC = 10ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  evt_done = '0, evt_uirq = '0, evt_perr = '0;
    logic [1:0]  eng_reset, eng_go, eng_busy, irq;
    logic [3:0]  pio_mode;
    logic [31:0] cpb_count, fifo_in_thr, fifo_out_thr;
    logic [63:0] cpb_next;

    int checks = 0, errors = 0;
    bit done = 0;

    always #(CYC/2) clk = ~clk;

    pktdma_chan_ctrl i_pktdma_chan_ctrl (.*);

    // Behavioural reference state.
    bit        m_mask[2], m_rst[2], m_go[2], m_busy[2];
    bit [1:0]  m_pio[2];
    bit [7:0]  m_stat[2];
    bit [15:0] m_cnt[2], m_fin[2], m_fout[2];
    bit [31:0] m_ptr[2];
    bit [7:0]  m_lock;
    bit [31:0] m_rdata;

    function automatic bit [31:0] mread(bit [7:0] a);
        if (a == 8'hC7) return {24'h0, m_lock};
        for (int c = 0; c < 2; c++) begin
            bit [7:0] b = 8'h80 + 8'h20 * c[7:0];
            if (a == b)         return {23'h0, m_mask[c], 2'b00, m_rst[c], 3'b000, m_pio[c]};
            if (a == b + 8'h02) return {24'h0, m_stat[c]};
            if (a == b + 8'h04) return {16'h0, m_cnt[c]};
            if (a == b + 8'h0C) return m_ptr[c];
            if (a == b + 8'h14) return {16'h0, m_fin[c]};
            if (a == b + 8'h16) return {16'h0, m_fout[c]};
        end
        return 32'h0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < 2; c++) begin
                m_mask[c] = 1; m_rst[c] = 0; m_go[c] = 0; m_busy[c] = 0; m_pio[c] = 0;
                m_stat[c] = 0; m_cnt[c] = 0; m_fin[c] = 0; m_fout[c] = 0; m_ptr[c] = 0;
            end
            m_lock = 0; m_rdata = 0;
        end else begin
            m_rdata = bus_rd ? mread(bus_addr) : 32'h0;
            for (int c = 0; c < 2; c++) begin
                bit [7:0] b;
                bit wc, gonew, rs;
                bit [7:0] ev;
                b  = 8'h80 + 8'h20 * c[7:0];
                wc = bus_wr && bus_addr == b;
                gonew = wc && bus_wdata[7] && !bus_wdata[5] && !m_rst[c] && m_lock == 7;
                if (wc) begin m_mask[c] = bus_wdata[8]; m_rst[c] = bus_wdata[5]; m_pio[c] = bus_wdata[1:0]; end
                ev = {1'b0, evt_done[c], 1'b0, evt_uirq[c], 3'b000, evt_perr[c]};
                rs = bus_rd && bus_addr == b + 8'h02;
                if (m_rst[c]) m_stat[c] = 0; else m_stat[c] = (rs ? 8'h0 : m_stat[c]) | ev;
                if (m_rst[c]) m_busy[c] = 0; else if (gonew) m_busy[c] = 1; else if (evt_done[c]) m_busy[c] = 0;
                m_go[c] = gonew;
                if (bus_wr && bus_addr == b + 8'h04) m_cnt[c] = bus_wdata[15:0];
                if (bus_wr && bus_addr == b + 8'h0C) m_ptr[c] = bus_wdata & 32'hFFFF_FFF8;
                if (bus_wr && bus_addr == b + 8'h14) m_fin[c] = bus_wdata[15:0];
                if (bus_wr && bus_addr == b + 8'h16) m_fout[c] = bus_wdata[15:0];
            end
            if (bus_wr && bus_addr == 8'hC7 && m_lock != 7) m_lock = bus_wdata[7:0];
        end
    end

    task automatic cmp(string req, string what, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s got %0h exp %0h", req, what, got, exp);
        end
    endtask

    // Per-cycle comparison against the reference model.
    always @(negedge clk) if (rst_n) begin
        cmp("R1", "bus_rdata", bus_rdata, m_rdata);
        for (int c = 0; c < 2; c++) begin
            cmp("R3", "eng_go", eng_go[c], m_go[c]);
            cmp("R5", "eng_reset", eng_reset[c], m_rst[c]);
            cmp("R10", "eng_busy", eng_busy[c], m_busy[c]);
            cmp("R8", "irq", irq[c], (m_stat[c] != 0) && !m_mask[c]);
            cmp("R2", "pio_mode", pio_mode[2*c +: 2], m_pio[c]);
            cmp("R1", "cpb_count", cpb_count[16*c +: 16], m_cnt[c]);
            cmp("R9", "cpb_next", cpb_next[32*c +: 32], m_ptr[c]);
            cmp("R1", "fifo_in_thr", fifo_in_thr[16*c +: 16], m_fin[c]);
            cmp("R1", "fifo_out_thr", fifo_out_thr[16*c +: 16], m_fout[c]);
        end
    end

    task automatic wr(bit [7:0] a, bit [31:0] d);
        @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 0;
    endtask

    task automatic rd(bit [7:0] a, output bit [31:0] d);
        @(negedge clk); bus_rd = 1; bus_addr = a;
        @(negedge clk); bus_rd = 0; d = bus_rdata;
    endtask

    task automatic pulse(int c, int kind);
        @(negedge clk);
        if (kind == 0) evt_done[c] = 1; else if (kind == 1) evt_uirq[c] = 1; else evt_perr[c] = 1;
        @(negedge clk); evt_done = 0; evt_uirq = 0; evt_perr = 0;
    endtask

    initial begin
        bit [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1;
        rd(8'h80, d);  cmp("R11", "ctrl reset", d, 32'h100);
        rd(8'hC7, d);  cmp("R11", "lock reset", d, 0);
        cmp("R11", "irq reset", irq, 0);
        wr(8'h80, 32'h83);
        cmp("R3", "go without key", eng_go, 0);
        cmp("R2", "pio mode 3", pio_mode[1:0], 3);
        wr(8'hC7, 5);  rd(8'hC7, d); cmp("R4", "lock holds 5", d, 5);
        wr(8'hC7, 7);  wr(8'hC7, 3); rd(8'hC7, d); cmp("R4", "lock sticky", d, 7);
        wr(8'h80, 32'h83);
        cmp("R3", "go pulse", eng_go, 2'b01);
        cmp("R10", "busy set", eng_busy, 2'b01);
        @(negedge clk); cmp("R3", "go single cycle", eng_go, 0);
        rd(8'h80, d);  cmp("R2", "go reads zero", d, 32'h3);
        pulse(0, 0);
        cmp("R10", "busy cleared by done", eng_busy, 0);
        cmp("R8", "irq unmasked", irq, 2'b01);
        rd(8'h82, d);  cmp("R6", "done latched bit6", d, 32'h40);
        rd(8'h82, d);  cmp("R7", "cleared after read", d, 0);
        wr(8'h80, 32'h103);
        pulse(0, 1);
        cmp("R8", "irq masked", irq, 0);
        @(negedge clk); bus_rd = 1; bus_addr = 8'h82; evt_perr[0] = 1;
        @(negedge clk); bus_rd = 0; evt_perr = 0; d = bus_rdata;
        cmp("R7", "read returns uirq bit4", d, 32'h10);
        rd(8'h82, d);  cmp("R7", "event during read kept", d, 32'h01);
        wr(8'h80, 32'h83);
        cmp("R10", "busy before reset", eng_busy, 2'b01);
        wr(8'h80, 32'hA3);
        cmp("R3", "go with reset dropped", eng_go, 0);
        cmp("R5", "reset high", eng_reset, 2'b01);
        cmp("R5", "busy low in reset", eng_busy, 0);
        pulse(0, 2);
        rd(8'h82, d);  cmp("R5", "event ignored in reset", d, 0);
        wr(8'h80, 32'h83);
        cmp("R3", "go with stored reset dropped", eng_go, 0);
        cmp("R5", "reset released", eng_reset, 0);
        wr(8'h80, 32'h83);
        cmp("R3", "go after reset", eng_go, 2'b01);
        wr(8'hA0, 32'h82);
        cmp("R12", "ch1 go only", eng_go, 2'b10);
        rd(8'h80, d);  cmp("R12", "ch0 ctrl intact", d, 32'h3);
        wr(8'h8C, 32'h12345677);
        rd(8'h8C, d);  cmp("R9", "ptr low bits", d, 32'h12345670);
        wr(8'h84, 32'h1); cmp("R1", "count", cpb_count[15:0], 1);
        wr(8'h94, 32'h100); wr(8'h96, 32'h100);
        rd(8'h96, d);  cmp("R1", "out threshold", d, 32'h100);
        wr(8'hB4, 32'h55);
        cmp("R12", "ch1 fifo", fifo_in_thr[31:16], 16'h55);
        cmp("R12", "ch0 fifo kept", fifo_in_thr[15:0], 16'h100);
        rd(8'h90, d);  cmp("R12", "unmapped zero", d, 0);
        repeat (3) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CYC * 20000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule